// File: doc/BRIEF.md
# Interrupt line mask and acknowledge forwarder

This block sits between a group of peripheral interrupt lines and a larger parent interrupt controller. Each local line maps to exactly one parent input, and the local lines occupy a contiguous run of the parent's input space. The run starts at a build-time base index. A small slave bus with 16-bit registers gives software two banks. The mask bank holds lines off. The acknowledge bank ends the service of a latched event.

In the default build, a rising input edge is caught in a per-line pending latch. The latch drives the parent line, and only a software acknowledge clears it. A build parameter can leave the acknowledge logic out. In that build each parent line follows its input level, gated by the mask. Trigger type, priority and CPU routing are handled by the parent.

Top module: `irq_fwd_top`

## Requirements
- R1: While reset is held and on the first cycle after it, every implemented mask bit is 1, every pending latch is clear and every parent output is 0. A mask register reads 0xFFFF, with any bits above the line count reading 0.
- R2: Local line n drives parent output PARENT_BASE+n. Every parent output outside PARENT_BASE to PARENT_BASE+NUM_LINES-1 stays 0.
- R3: Line n is controlled by bit (n mod 16) of a 16-bit register. The mask register for line n is at byte offset 4*(n div 16). The acknowledge register is at byte offset 0x20 + 4*(n div 16).
- R4: When a line's mask bit is 1, its parent output is 0. When the bit is 0, the parent output carries the line's state.
- R5: A mask register reads back the value last written to it, limited to the implemented lines.
- R6: With acknowledge built in, a 0-to-1 change on an input sets that line's pending latch at the next clock edge. The latch stays set after the input falls.
- R7: Writing 1 to a line's acknowledge bit clears its pending latch at that clock edge. Bits written as 0 change nothing. Acknowledge registers always read 0.
- R8: If a new rising edge and an acknowledge of the same line fall in the same cycle, the latch stays set.
- R9: A rising edge on a masked line is still latched. The parent output goes high once the line is unmasked, with no new edge needed.
- R10: Without acknowledge logic, each parent output equals input AND NOT mask, with no clock delay. Writes to the acknowledge bank have no effect.
- R11: Reads of offsets with no register behind them return 0. This covers misaligned offsets, offsets 0x30 and above, and registers past the line count. Writes to those offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_LINES | Peripheral interrupt lines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset within the register window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr during a read |
| parent_irq | output | PARENT_WIDTH | Lines toward the parent controller |

## Verification
Edges are driven on the lowest line, the highest line and a middle line. This shows whether the base offset and the register-and-bit split are both correct, rather than only correct for register 0. Edges are then held, dropped and re-raised, which separates a real pending latch from a level pass-through. An edge that lands in the same cycle as its own acknowledge shows which action wins. Acknowledges are also sent to the wrong bit or register while a line is pending, to prove that bit selection is exact. A second instance built without acknowledge logic checks level following with no delay, and checks that acknowledge writes do nothing there.

// File: rtl/irq_fwd_pkg.sv
// Shared constants for the interrupt forwarder register window.
// Assumes byte addressing with 32-bit register stride and 16-bit data.
package irq_fwd_pkg;
    localparam int REG_W       = 16;
    localparam int ADDR_W      = 6;
    localparam int MAX_LINES   = 64;
    localparam int MAX_REGS    = MAX_LINES / REG_W;
    localparam logic [1:0] BANK_EOI = 2'b10;   // addr[5:4] for acknowledge bank

    // Number of 16-bit registers needed to cover a line count.
    function automatic int regs_for(input int lines);
        return (lines + REG_W - 1) / REG_W;
    endfunction
endpackage

// File: rtl/irq_fwd_regs.sv
// Register file: mask bank (readable, resets to all-masked) and an
// acknowledge bank that produces one-cycle clear pulses per line.
// Assumes bus_addr is a byte offset; misaligned offsets decode to nothing.
module irq_fwd_regs
    import irq_fwd_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter bit HAS_EOI   = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    output logic [NUM_LINES-1:0] mask_q,
    output logic [NUM_LINES-1:0] eoi_pulse
);
    localparam int NREG = regs_for(NUM_LINES);
    localparam int PADW = NREG * REG_W;

    logic            aligned;
    logic            in_mask;
    logic            in_eoi;
    logic [2:0]      idx_m;
    logic [1:0]      idx_e;
    logic [NREG-1:0] mask_we;
    logic [NREG-1:0] eoi_we;
    logic [PADW-1:0] mask_pad;

    // Address decode into bank and register index.
    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        in_mask = aligned && !bus_addr[5];
        in_eoi  = aligned && (bus_addr[5:4] == BANK_EOI);
        idx_m   = bus_addr[4:2];
        idx_e   = bus_addr[3:2];
    end

    // Per-register write enables for both banks.
    always_comb begin
        for (int k = 0; k < NREG; k++) begin
            mask_we[k] = bus_sel && bus_wr && in_mask && (int'(idx_m) == k);
            eoi_we[k]  = HAS_EOI && bus_sel && bus_wr && in_eoi && (int'(idx_e) == k);
        end
    end

    // Mask bank storage: all lines masked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else begin
            for (int n = 0; n < NUM_LINES; n++) begin
                if (mask_we[n / REG_W]) mask_q[n] <= bus_wdata[n % REG_W];
            end
        end
    end

    // Acknowledge pulses: one per line whose bit is written as 1.
    always_comb begin
        for (int n = 0; n < NUM_LINES; n++) begin
            eoi_pulse[n] = eoi_we[n / REG_W] && bus_wdata[n % REG_W];
        end
    end

    // Zero-extend mask storage to whole registers for readback.
    always_comb begin
        mask_pad = '0;
        mask_pad[NUM_LINES-1:0] = mask_q;
    end

    // Read mux: only implemented mask registers return data.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && in_mask) begin
            for (int k = 0; k < NREG; k++) begin
                if (int'(idx_m) == k) bus_rdata = mask_pad[k*REG_W +: REG_W];
            end
        end
    end
endmodule

// File: rtl/irq_fwd_line.sv
// One interrupt line. With HAS_EOI the line latches a rising edge until
// acknowledged (set wins over clear); without it the level passes through.
// The mask gates only the output, never the latch.
module irq_fwd_line #(
    parameter bit HAS_EOI = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_in,
    input  logic mask,
    input  logic eoi,
    output logic pend,
    output logic line_out
);
    if (HAS_EOI) begin : g_latch
        logic prev_q;
        logic pend_q;

        // Previous input sample for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= irq_in;
        end

        // Pending latch: rising edge sets, acknowledge clears, set wins.
        always_ff @(posedge clk) begin
            if (!rst_n)                  pend_q <= 1'b0;
            else if (irq_in && !prev_q)  pend_q <= 1'b1;
            else if (eoi)                pend_q <= 1'b0;
        end

        assign pend     = pend_q;
        assign line_out = pend_q && !mask;
    end else begin : g_level
        logic unused_nc;
        assign unused_nc = ^{clk, rst_n, eoi};
        assign pend      = 1'b0;
        assign line_out  = irq_in && !mask;
    end
endmodule

// File: rtl/irq_fwd_map.sv
// Places the local line vector at a fixed base within the parent vector.
// Assumes PARENT_BASE + NUM_LINES <= PARENT_WIDTH.
module irq_fwd_map #(
    parameter int NUM_LINES    = 64,
    parameter int PARENT_WIDTH = 128,
    parameter int PARENT_BASE  = 32
) (
    input  logic [NUM_LINES-1:0]    line_out,
    output logic [PARENT_WIDTH-1:0] parent_irq
);
    // Offset placement; unused parent inputs stay low.
    always_comb begin
        parent_irq = '0;
        parent_irq[PARENT_BASE +: NUM_LINES] = line_out;
    end
endmodule

// File: rtl/irq_fwd_top.sv
// Interrupt forwarder top: register file, per-line logic and parent mapping.
// Assumes 1 <= NUM_LINES <= 64 and the parent range fits PARENT_WIDTH.
module irq_fwd_top
    import irq_fwd_pkg::*;
#(
    parameter int NUM_LINES    = 64,
    parameter int PARENT_WIDTH = 128,
    parameter int PARENT_BASE  = 32,
    parameter bit HAS_EOI      = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_LINES-1:0]    irq_in,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [REG_W-1:0]        bus_wdata,
    output logic [REG_W-1:0]        bus_rdata,
    output logic [PARENT_WIDTH-1:0] parent_irq
);
    logic [NUM_LINES-1:0] mask_bits;
    logic [NUM_LINES-1:0] eoi_bits;
    logic [NUM_LINES-1:0] pend_bits;
    logic [NUM_LINES-1:0] line_out;

    irq_fwd_regs #(.NUM_LINES(NUM_LINES), .HAS_EOI(HAS_EOI)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mask_q    (mask_bits),
        .eoi_pulse (eoi_bits)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        irq_fwd_line #(.HAS_EOI(HAS_EOI)) u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_in   (irq_in[n]),
            .mask     (mask_bits[n]),
            .eoi      (eoi_bits[n]),
            .pend     (pend_bits[n]),
            .line_out (line_out[n])
        );
    end

    irq_fwd_map #(
        .NUM_LINES(NUM_LINES), .PARENT_WIDTH(PARENT_WIDTH), .PARENT_BASE(PARENT_BASE)
    ) u_map (
        .line_out   (line_out),
        .parent_irq (parent_irq)
    );
endmodule

// File: rtl/irq_fwd_chk.sv
// Property checker for irq_fwd_top, attached by bind below.
// Keeps its own input history so edge checks do not reuse design state.
module irq_fwd_chk #(
    parameter int NUM_LINES    = 64,
    parameter int PARENT_WIDTH = 128,
    parameter int PARENT_BASE  = 32,
    parameter bit HAS_EOI      = 1'b1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_LINES-1:0]    irq_in,
    input logic [NUM_LINES-1:0]    mask,
    input logic [NUM_LINES-1:0]    pend,
    input logic                    bus_sel,
    input logic                    bus_wr,
    input logic [5:0]              bus_addr,
    input logic [15:0]             bus_rdata,
    input logic [PARENT_WIDTH-1:0] parent_irq
);
    logic [NUM_LINES-1:0]    prev_in;
    logic [NUM_LINES-1:0]    rise_c;
    logic [NUM_LINES-1:0]    slice;
    logic [PARENT_WIDTH-1:0] win;
    logic                    eoi_wr;
    logic                    eoi_rd;

    // Checker-side input history.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_in <= '0;
        else        prev_in <= irq_in;
    end

    // Derived observation signals.
    always_comb begin
        rise_c = irq_in & ~prev_in;
        slice  = parent_irq[PARENT_BASE +: NUM_LINES];
        for (int i = 0; i < PARENT_WIDTH; i++)
            win[i] = (i >= PARENT_BASE) && (i < PARENT_BASE + NUM_LINES);
        eoi_wr = bus_sel && bus_wr  && (bus_addr[5:4] == 2'b10);
        eoi_rd = bus_sel && !bus_wr && (bus_addr[5:4] == 2'b10);
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((&mask) && (pend == '0) && (parent_irq == '0)));

    assert_outside_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (parent_irq & ~win) == '0);

    assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slice & mask) == '0);

    assert_eoi_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_rd |-> (bus_rdata == 16'h0000));

    if (HAS_EOI) begin : g_eoi_props
        assert_rise_latches_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (rise_c != '0) |=> ((pend & $past(rise_c)) == $past(rise_c)));

        assert_clear_needs_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ((~pend & $past(pend)) != '0) |-> $past(eoi_wr));
    end else begin : g_level_props
        assert_level_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
            slice == (irq_in & ~mask));
    end
endmodule

bind irq_fwd_top irq_fwd_chk #(
    .NUM_LINES(NUM_LINES), .PARENT_WIDTH(PARENT_WIDTH),
    .PARENT_BASE(PARENT_BASE), .HAS_EOI(HAS_EOI)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .mask       (mask_bits),
    .pend       (pend_bits),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .parent_irq (parent_irq)
);

// File: tb/sim_irq_fwd_top.sv
// Directed bench: u0 latches with acknowledge (40 lines at base 20),
// u1 is the level build (24 lines at base 4).
module sim_irq_fwd_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel0 = 1'b0, sel1 = 1'b0, wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata0, rdata1;
    logic [39:0] irq0 = '0;
    logic [23:0] irq1 = '0;
    logic [95:0] parent0;
    logic [31:0] parent1;
    logic [39:0] exp_pend = '0;
    logic [39:0] exp_mask = '1;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    irq_fwd_top #(.NUM_LINES(40), .PARENT_WIDTH(96), .PARENT_BASE(20), .HAS_EOI(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq0), .bus_sel(sel0), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata0), .parent_irq(parent0));

    irq_fwd_top #(.NUM_LINES(24), .PARENT_WIDTH(32), .PARENT_BASE(4), .HAS_EOI(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq1), .bus_sel(sel1), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata1), .parent_irq(parent1));

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [95:0] exp_parent0();
        return {56'b0, exp_pend & ~exp_mask} << 20;
    endfunction

    // Write through one clock edge; results visible on return (negedge).
    task automatic bus_write(input bit which, input logic [5:0] a, input logic [15:0] d);
        sel0 = !which; sel1 = which; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel0 = 1'b0; sel1 = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input bit which, input logic [5:0] a, output logic [15:0] d);
        sel0 = !which; sel1 = which; wr = 1'b0; addr = a;
        #1 d = which ? rdata1 : rdata0;
        sel0 = 1'b0; sel1 = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R1 parent0 idle", parent0, 0);
        chk("R1 parent1 idle", parent1, 0);
        bus_read(0, 6'h00, d); chk("R1 mask reg0", d, 16'hFFFF);
        bus_read(0, 6'h04, d); chk("R1 mask reg1", d, 16'hFFFF);
        bus_read(0, 6'h08, d); chk("R1 R11 mask reg2 upper bits", d, 16'h00FF);
        bus_read(0, 6'h0C, d); chk("R11 reg past count", d, 16'h0000);
        bus_read(0, 6'h20, d); chk("R7 ack reads zero", d, 16'h0000);
    endtask

    task automatic t_map_latch();
        bus_write(0, 6'h00, 16'h0000);
        bus_write(0, 6'h04, 16'h0000);
        bus_write(0, 6'h08, 16'h0000);
        exp_mask = '0;
        irq0[0] = 1'b1; irq0[39] = 1'b1;
        @(negedge clk);
        exp_pend[0] = 1'b1; exp_pend[39] = 1'b1;
        chk("R2 R6 edges on first and last line", parent0, exp_parent0());
        chk("R2 last line at base+39", parent0[59], 1'b1);
        irq0 = '0;
        @(negedge clk);
        chk("R6 latch holds after input falls", parent0, exp_parent0());
    endtask

    task automatic t_ack();
        bus_write(0, 6'h20, 16'h0001);
        exp_pend[0] = 1'b0;
        chk("R7 ack clears line 0", parent0, exp_parent0());
        bus_write(0, 6'h28, 16'h0080);
        exp_pend[39] = 1'b0;
        chk("R3 R7 ack reg2 bit7 clears line 39", parent0, exp_parent0());
        irq0[18] = 1'b1;
        @(negedge clk);
        exp_pend[18] = 1'b1;
        bus_write(0, 6'h24, 16'h0001);
        chk("R3 ack of wrong bit leaves line 18", parent0, exp_parent0());
        bus_write(0, 6'h20, 16'h0004);
        chk("R3 ack of wrong register leaves line 18", parent0, exp_parent0());
        bus_write(0, 6'h24, 16'h0004);
        exp_pend[18] = 1'b0;
        chk("R7 ack reg1 bit2 clears line 18", parent0, exp_parent0());
        irq0[18] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_mask();
        logic [15:0] d;
        bus_write(0, 6'h04, 16'h0002);
        exp_mask[17] = 1'b1;
        irq0[17] = 1'b1;
        @(negedge clk);
        exp_pend[17] = 1'b1;
        chk("R4 R9 masked edge held low", parent0, exp_parent0());
        bus_read(0, 6'h04, d); chk("R5 mask readback", d, 16'h0002);
        bus_write(0, 6'h04, 16'h0000);
        exp_mask[17] = 1'b0;
        chk("R9 unmask reveals latched edge", parent0[37], 1'b1);
        bus_write(0, 6'h24, 16'h0002);
        exp_pend[17] = 1'b0;
        irq0[17] = 1'b0;
        @(negedge clk);
        chk("R7 line 17 cleared", parent0, exp_parent0());
        bus_write(0, 6'h04, 16'hA5A5);
        bus_read(0, 6'h04, d); chk("R5 mask pattern readback", d, 16'hA5A5);
        bus_write(0, 6'h04, 16'h0000);
    endtask

    task automatic t_same_cycle();
        irq0[2] = 1'b1;
        @(negedge clk);
        exp_pend[2] = 1'b1;
        irq0[2] = 1'b0;
        @(negedge clk);
        irq0[2] = 1'b1;
        bus_write(0, 6'h20, 16'h0004);
        chk("R8 edge wins over same-cycle ack", parent0, exp_parent0());
        bus_write(0, 6'h20, 16'h0004);
        exp_pend[2] = 1'b0;
        chk("R7 ack clears while input stays high", parent0, exp_parent0());
        irq0[2] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_unimpl();
        logic [15:0] d;
        irq0[1] = 1'b1;
        @(negedge clk);
        exp_pend[1] = 1'b1;
        bus_write(0, 6'h0C, 16'hFFFF);
        bus_write(0, 6'h30, 16'hFFFF);
        bus_write(0, 6'h3C, 16'hFFFF);
        bus_write(0, 6'h02, 16'hFFFF);
        bus_write(0, 6'h22, 16'hFFFF);
        bus_write(0, 6'h2C, 16'hFFFF);
        chk("R11 ignored writes keep outputs", parent0, exp_parent0());
        bus_read(0, 6'h00, d); chk("R11 mask reg0 unchanged", d, 16'h0000);
        bus_read(0, 6'h30, d); chk("R11 read 0x30", d, 16'h0000);
        bus_read(0, 6'h02, d); chk("R11 misaligned read", d, 16'h0000);
        bus_write(0, 6'h08, 16'hFFFF);
        bus_read(0, 6'h08, d); chk("R11 bits above count read 0", d, 16'h00FF);
        bus_write(0, 6'h08, 16'h0000);
        bus_write(0, 6'h20, 16'h0002);
        exp_pend[1] = 1'b0;
        irq0[1] = 1'b0;
        @(negedge clk);
        chk("R7 final clear", parent0, exp_parent0());
    endtask

    task automatic t_level_build();
        logic [15:0] d;
        bus_read(1, 6'h00, d); chk("R1 level build mask reg0", d, 16'hFFFF);
        bus_read(1, 6'h04, d); chk("R1 level build mask reg1", d, 16'h00FF);
        irq1[3] = 1'b1;
        #1 chk("R4 level build masked", parent1, 0);
        bus_write(1, 6'h00, 16'h0000);
        chk("R10 level passes unmasked", parent1, 32'h1 << 7);
        bus_write(1, 6'h20, 16'h0008);
        chk("R10 ack write has no effect", parent1, 32'h1 << 7);
        irq1[3] = 1'b0;
        #1 chk("R10 output drops with input", parent1, 0);
        irq1[20] = 1'b1;
        #1 chk("R2 R10 line 20 to parent 24", parent1, 0);
        bus_write(1, 6'h04, 16'h0000);
        chk("R2 R10 line 20 unmasked", parent1, 32'h1 << 24);
        bus_read(1, 6'h24, d); chk("R7 level build ack reads zero", d, 16'h0000);
        irq1 = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map_latch();
        t_ack();
        t_mask();
        t_same_cycle();
        t_unimpl();
        t_level_build();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule